// File: doc/BRIEF.md
# Prescaled Down-Counting Interval Timer

This block is a 32-bit down counter behind a small word-addressed register window. Software picks one of three tick sources, or none, and divides it with a 12-bit prescaler. It loads a start value and turns the counter on. On each prescaled tick the counter steps down by one. When it reaches zero, it either restarts from the load register (reload mode) or rolls over to all-ones (free-run mode).

A compare register is checked against the live count on every tick. A match sets a sticky flag, which software clears by writing a one to it. The single interrupt line follows that flag, gated by the compare enable and the run enable. A software reset clears most of the control word and the timer state, but it keeps the run and mode enables.

The tick sources arrive as clock-enable strobes in the system clock domain: a fast peripheral strobe, a high-rate peripheral strobe and a slow strobe of about 32 kHz.

Top module: `tick_down_timer`

## Requirements
- R1: The register index is the byte address divided by 4: 0 control, 1 status, 2 load, 3 compare, 4 count. The count register is read-only, and writes to it are ignored. Reads return, one clock after the address, the register value or zero for other indices. After reset, control, status and compare are 0, and load and count are 0xFFFFFFFF.
- R2: Control stores bits 25:0 of a write, and bits 31:26 read as zero. The control fields are:
  - bit0: run enable
  - bit1: start mode
  - bit2: compare enable
  - bit3: reload mode
  - bit4: software reset
  - bit5: overwrite-on-load
  - bits 9:6: stored-only low-power and debug bits
  - bits 11:10: source select
  - bits 23:12: prescale
- R3: The source select value chooses the tick: 0 gives no tick and the count stays frozen, 1 the fast strobe, 2 the high-rate strobe, 3 the slow strobe.
- R4: The counter steps once every prescale+1 selected strobes while running. Prescaler phase restarts when the timer is stopped or when the source or prescale field changes.
- R5: When run enable goes from 0 to 1 with start mode set, the count is loaded. It takes the load register if the written reload mode bit is set, otherwise 0xFFFFFFFF. With start mode clear, the count keeps its value.
- R6: On a tick at count zero, the count becomes the load register in reload mode and 0xFFFFFFFF in free-run mode. Otherwise a tick decrements the count.
- R7: A write to load always stores the value. If overwrite-on-load is set, the same write also forces the count to that value.
- R8: While run enable is 0, the count holds its value.
- R9: While running with compare enable set, a tick taken when the count equals the compare register sets status bit0. With compare enable clear, the flag is never set.
- R10: Writing status with bit0 = 1 clears the flag, and writing bit0 = 0 leaves it unchanged.
- R11: The interrupt output is high exactly when the flag, compare enable and run enable are all 1.
- R12: A control write with bit4 set keeps only bits 0, 1 and 6..9 of the written word. It also clears the flag and sets both load and count to 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_fast | input | 1 | Fast peripheral clock-enable strobe (source 1) |
| tick_hf | input | 1 | High-rate peripheral clock-enable strobe (source 2) |
| tick_slow | input | 1 | Slow 32 kHz clock-enable strobe (source 3) |
| reg_wr | input | 1 | Write strobe for the register window |
| reg_addr | input | 5 | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Active-high compare interrupt |

## Verification
The bench stops the counter after an exact number of running edges and checks the residual count. A prescaler that drops or adds a phase at enable or at a configuration change shows up as an off-by-one in that count. Wrap checks straddle zero in both modes: a design that reloads in free-run mode, or returns to the load value one step late, leaves the wrong residue. The software reset is checked for over-clearing the kept enables and under-clearing prescale and source. Status writes of zero and clearing compare enable with a pending flag catch a flag that is cleared by any write, and an interrupt line that is not gated.

// File: rtl/tdt_pkg.sv
package tdt_pkg;
  localparam int CR_W     = 26;
  localparam int B_RUN    = 0;
  localparam int B_START  = 1;
  localparam int B_CMPEN  = 2;
  localparam int B_RELOAD = 3;
  localparam int B_SRST   = 4;
  localparam int B_OVWR   = 5;
  localparam int B_LP_LO  = 6;
  localparam int B_LP_HI  = 9;
  localparam int B_SRC_LO = 10;
  localparam int SRC_W    = 2;
  localparam int B_PS_LO  = 12;
  localparam int PS_W     = 12;

  localparam logic [CR_W-1:0] KEEP_ON_SRST =
      CR_W'((1 << B_RUN) | (1 << B_START) | (((1 << (B_LP_HI - B_LP_LO + 1)) - 1) << B_LP_LO));

  typedef enum logic [2:0] {
    IDX_CTRL = 3'd0,
    IDX_STAT = 3'd1,
    IDX_LOAD = 3'd2,
    IDX_CMP  = 3'd3,
    IDX_CNT  = 3'd4
  } reg_idx_e;
endpackage

// File: rtl/tdt_prescaler.sv
module tdt_prescaler #(
  parameter int PW = 12,
  parameter int SW = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic            restart,
  input  logic [SW-1:0]   src_sel,
  input  logic [(1<<SW)-1:0] src_en,
  input  logic [PW-1:0]   divisor,
  output logic            tick
);
  logic [PW-1:0] phase_q;
  logic          sel_en;
  logic          wrap;

  assign sel_en = src_en[src_sel];
  assign wrap   = (phase_q == divisor);
  assign tick   = run && sel_en && wrap;

  always_ff @(posedge clk) begin
    if (rst || restart || !run) begin
      phase_q <= '0;
    end else if (sel_en) begin
      phase_q <= wrap ? '0 : phase_q + 1'b1;
    end
  end
endmodule

// File: rtl/tdt_counter.sv
module tdt_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  input  logic         tick,
  input  logic         reload_mode,
  input  logic [W-1:0] reload_val,
  input  logic [W-1:0] cmp_val,
  output logic [W-1:0] count,
  output logic         hit
);
  localparam logic [W-1:0] ALL_ONES = '1;

  assign hit = tick && !load_en && (count == cmp_val);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= ALL_ONES;
    end else if (load_en) begin
      count <= load_val;
    end else if (tick) begin
      if (count == '0) count <= reload_mode ? reload_val : ALL_ONES;
      else             count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/tick_down_timer.sv
module tick_down_timer
  import tdt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_fast,
  input  logic              tick_hf,
  input  logic              tick_slow,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_o
);
  localparam int IDX_W = ADDR_W - 2;
  localparam logic [DATA_W-1:0] ALL_ONES = '1;

  logic [CR_W-1:0]   cr_q;
  logic [DATA_W-1:0] load_q;
  logic [DATA_W-1:0] cmp_q;
  logic              flag_q;
  logic [DATA_W-1:0] count;
  logic              hit;
  logic              tick;

  logic [IDX_W-1:0]  idx;
  logic              wr_ctrl, wr_stat, wr_load, wr_cmp;
  logic [CR_W-1:0]   cr_wval, cr_new;
  logic              srst, en_rise, restart;
  logic              cnt_load;
  logic [DATA_W-1:0] cnt_val;

  assign idx     = reg_addr[ADDR_W-1:2];
  assign wr_ctrl = reg_wr && (idx == IDX_W'(IDX_CTRL));
  assign wr_stat = reg_wr && (idx == IDX_W'(IDX_STAT));
  assign wr_load = reg_wr && (idx == IDX_W'(IDX_LOAD));
  assign wr_cmp  = reg_wr && (idx == IDX_W'(IDX_CMP));

  assign cr_wval = reg_wdata[CR_W-1:0];
  assign srst    = wr_ctrl && cr_wval[B_SRST];
  assign cr_new  = cr_wval[B_SRST] ? (cr_wval & KEEP_ON_SRST) : cr_wval;
  assign en_rise = wr_ctrl && cr_new[B_RUN] && !cr_q[B_RUN] && cr_new[B_START];
  assign restart = wr_ctrl &&
                   (cr_new[B_PS_LO+:PS_W+SRC_W] != cr_q[B_PS_LO+:PS_W+SRC_W] ||
                    cr_new[B_SRC_LO+:SRC_W]     != cr_q[B_SRC_LO+:SRC_W]);

  always_comb begin
    cnt_load = 1'b0;
    cnt_val  = ALL_ONES;
    if (srst) begin
      cnt_load = 1'b1;
    end else if (en_rise) begin
      cnt_load = 1'b1;
      cnt_val  = cr_new[B_RELOAD] ? load_q : ALL_ONES;
    end else if (wr_load && cr_q[B_OVWR]) begin
      cnt_load = 1'b1;
      cnt_val  = reg_wdata;
    end
  end

  tdt_prescaler #(.PW(PS_W), .SW(SRC_W)) u_psc (
    .clk     (clk),
    .rst     (rst),
    .run     (cr_q[B_RUN]),
    .restart (restart),
    .src_sel (cr_q[B_SRC_LO+:SRC_W]),
    .src_en  ({tick_slow, tick_hf, tick_fast, 1'b0}),
    .divisor (cr_q[B_PS_LO+:PS_W]),
    .tick    (tick)
  );

  tdt_counter #(.W(DATA_W)) u_cnt (
    .clk         (clk),
    .rst         (rst),
    .load_en     (cnt_load),
    .load_val    (cnt_val),
    .tick        (tick),
    .reload_mode (cr_q[B_RELOAD]),
    .reload_val  (load_q),
    .cmp_val     (cmp_q),
    .count       (count),
    .hit         (hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cr_q   <= '0;
      load_q <= ALL_ONES;
      cmp_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (wr_ctrl) cr_q <= cr_new;
      if (srst)         load_q <= ALL_ONES;
      else if (wr_load) load_q <= reg_wdata;
      if (wr_cmp) cmp_q <= reg_wdata;
      if (srst)                         flag_q <= 1'b0;
      else if (hit && cr_q[B_CMPEN])    flag_q <= 1'b1;
      else if (wr_stat && reg_wdata[0]) flag_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (idx)
        IDX_W'(IDX_CTRL): reg_rdata <= DATA_W'(cr_q);
        IDX_W'(IDX_STAT): reg_rdata <= DATA_W'(flag_q);
        IDX_W'(IDX_LOAD): reg_rdata <= load_q;
        IDX_W'(IDX_CMP):  reg_rdata <= cmp_q;
        IDX_W'(IDX_CNT):  reg_rdata <= count;
        default:          reg_rdata <= '0;
      endcase
    end
  end

  assign irq_o = flag_q && cr_q[B_CMPEN] && cr_q[B_RUN];
endmodule

// File: rtl/tdt_checker.sv
module tdt_checker
  import tdt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              irq_o,
  input logic [CR_W-1:0]   cr_q,
  input logic              flag_q,
  input logic [DATA_W-1:0] count,
  input logic [DATA_W-1:0] load_q
);
  localparam int IDX_W = ADDR_W - 2;
  logic [IDX_W-1:0] idx;
  assign idx = reg_addr[ADDR_W-1:2];

  // R8
  a_r8_hold_when_stopped: assert property (@(posedge clk) disable iff (rst)
    (!cr_q[B_RUN] && !reg_wr) |=> $stable(count));

  // R9
  a_r9_flag_needs_compare: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q) |-> ($past(cr_q[B_CMPEN]) && $past(cr_q[B_RUN])));

  // R10
  a_r10_w1c_clears: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && idx == IDX_W'(IDX_STAT) && reg_wdata[0] && !cr_q[B_RUN]) |=> !flag_q);

  // R11
  a_r11_irq_gated: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (flag_q && cr_q[B_RUN]));

  // R12
  a_r12_soft_reset: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && idx == IDX_W'(IDX_CTRL) && reg_wdata[B_SRST])
      |=> (count == '1 && load_q == '1 && !flag_q));
endmodule

bind tick_down_timer tdt_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .irq_o     (irq_o),
  .cr_q      (cr_q),
  .flag_q    (flag_q),
  .count     (count),
  .load_q    (load_q)
);

// File: tb/sim_tick_down_timer.sv
module sim_tick_down_timer;
  localparam int AW = 5;
  localparam logic [31:0] RUN = 32'h1, START = 32'h2, CMPEN = 32'h4, RLD = 32'h8;
  localparam logic [31:0] SRST = 32'h10, OVWR = 32'h20, STOPB = 32'h200;
  localparam logic [31:0] MAXV = 32'hFFFF_FFFF;
  localparam logic [4:0] A_CTRL = 5'd0, A_STAT = 5'd4, A_LOAD = 5'd8, A_CMP = 5'd12, A_CNT = 5'd16;

  // vector: src, prescale, idle edges, load value, expected residual count
  localparam int NV = 5;
  localparam logic [31:0] VEC [NV][5] = '{
    '{32'd1, 32'd0, 32'd9,  32'd100, 32'd90},
    '{32'd1, 32'd1, 32'd9,  32'd100, 32'd95},
    '{32'd2, 32'd3, 32'd10, 32'd50,  32'd48},
    '{32'd2, 32'd0, 32'd0,  32'd7,   32'd6},
    '{32'd0, 32'd0, 32'd9,  32'd40,  32'd40}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic tick_fast = 1'b1, tick_hf = 1'b1, tick_slow = 1'b0;
  logic reg_wr = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata, rv;
  logic irq_o;
  int runs = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tick_down_timer u0 (.clk(clk), .rst(rst), .tick_fast(tick_fast), .tick_hf(tick_hf),
    .tick_slow(tick_slow), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_o(irq_o));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    runs++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1 reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    @(negedge clk); reg_addr = a;
    @(posedge clk); @(negedge clk); v = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic pulse_slow();
    @(negedge clk); tick_slow = 1'b1;
    @(negedge clk); tick_slow = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      runs++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end

  initial begin
    idle(3); @(negedge clk); rst = 1'b0;
    // R1 reset values
    rd(A_CTRL, rv); chk("R1 ctrl reset", rv, 0);
    rd(A_STAT, rv); chk("R1 status reset", rv, 0);
    rd(A_LOAD, rv); chk("R1 load reset", rv, MAXV);
    rd(A_CMP, rv);  chk("R1 compare reset", rv, 0);
    rd(A_CNT, rv);  chk("R1 count reset", rv, MAXV);
    @(negedge clk); chk("R11 irq reset", irq_o, 0);
    wr(A_CNT, 32'h1234);
    rd(A_CNT, rv);  chk("R1 count write ignored", rv, MAXV);
    // R2 width of control
    wr(A_CTRL, 32'hFD00_0000);
    rd(A_CTRL, rv); chk("R2 upper bits dropped", rv, 32'h0100_0000);

    // R3 R4 R6 table walk
    for (int i = 0; i < NV; i++) begin
      wr(A_CTRL, 0);
      wr(A_LOAD, VEC[i][3]);
      wr(A_CTRL, RUN | START | RLD | (VEC[i][0] << 10) | (VEC[i][1] << 12));
      idle(int'(VEC[i][2]));
      wr(A_CTRL, 0);
      rd(A_CNT, rv);
      chk($sformatf("R3/R4 vector %0d", i), rv, VEC[i][4]);
    end

    // R8 stopped count holds
    idle(10);
    rd(A_CNT, rv); chk("R8 hold while stopped", rv, 32'd40);

    // R6 reload wrap: 3,2,1,0,3,2,1
    wr(A_LOAD, 3);
    wr(A_CTRL, RUN | START | RLD | (1 << 10));
    idle(5);
    wr(A_CTRL, 0);
    rd(A_CNT, rv); chk("R6 reload wrap", rv, 32'd1);

    // R7 load without overwrite stores only
    wr(A_LOAD, 55);
    rd(A_LOAD, rv); chk("R7 load stored", rv, 32'd55);
    rd(A_CNT, rv);  chk("R7 count untouched", rv, 32'd1);

    // R7 overwrite, R5 start-mode clear keeps value, R6 free-run wrap
    wr(A_CTRL, OVWR);
    wr(A_LOAD, 2);
    rd(A_CNT, rv); chk("R7 overwrite forces count", rv, 32'd2);
    wr(A_CTRL, RUN | OVWR | (1 << 10));
    idle(3);
    wr(A_CTRL, 0);
    rd(A_CNT, rv); chk("R5/R6 keep value then free-run wrap", rv, 32'hFFFF_FFFE);

    // R5 start mode without reload loads all-ones
    wr(A_LOAD, 77);
    wr(A_CTRL, RUN | START | (1 << 10));
    wr(A_CTRL, 0);
    rd(A_CNT, rv); chk("R5 free-run start", rv, 32'hFFFF_FFFE);

    // R3 slow strobe source
    wr(A_LOAD, 10);
    wr(A_CTRL, RUN | START | RLD | (3 << 10));
    tick_fast = 1'b0; tick_hf = 1'b0;
    idle(10);
    pulse_slow(); pulse_slow(); pulse_slow();
    wr(A_CTRL, 0);
    tick_fast = 1'b1; tick_hf = 1'b1;
    rd(A_CNT, rv); chk("R3 slow source steps", rv, 32'd7);

    // R9 compare disabled never flags
    wr(A_CMP, 5);
    wr(A_LOAD, 20);
    wr(A_CTRL, RUN | START | RLD | (1 << 10));
    idle(30);
    wr(A_CTRL, 0);
    rd(A_STAT, rv); chk("R9 no flag without compare enable", rv, 0);

    // R9 R11 compare match
    wr(A_CTRL, RUN | START | RLD | CMPEN | (1 << 10));
    idle(5);
    @(negedge clk); chk("R9 no flag before match", irq_o, 0);
    idle(20);
    @(negedge clk); chk("R9/R11 irq after match", irq_o, 1);
    wr(A_CTRL, RUN | START | RLD | (1 << 10));
    @(negedge clk); chk("R11 irq masked by compare enable", irq_o, 0);
    wr(A_CTRL, CMPEN);
    @(negedge clk); chk("R11 irq masked by run enable", irq_o, 0);
    rd(A_STAT, rv); chk("R9 flag still set", rv, 1);
    // R10 write-one-to-clear
    wr(A_STAT, 0);
    rd(A_STAT, rv); chk("R10 write zero no effect", rv, 1);
    wr(A_STAT, 1);
    rd(A_STAT, rv); chk("R10 write one clears", rv, 0);

    // R12 software reset
    wr(A_CTRL, RUN | START | CMPEN | RLD | STOPB | (1 << 10) | (5 << 12));
    wr(A_LOAD, 123);
    wr(A_CTRL, RUN | START | CMPEN | RLD | STOPB | (1 << 10) | (5 << 12) | SRST);
    rd(A_CTRL, rv); chk("R12 kept control bits", rv, RUN | START | STOPB);
    rd(A_LOAD, rv); chk("R12 load set", rv, MAXV);
    rd(A_CNT, rv);  chk("R12 count set", rv, MAXV);
    rd(A_STAT, rv); chk("R12 flag clear", rv, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule